// File: doc/BRIEF.md
# Pipelined Burst SRAM with Double-Cycle Deselect

This block is a cycle-accurate, synthesizable model of a single-clock burst SRAM. Each word holds four 9-bit lanes, eight data bits and one parity bit per lane. Data travels in both directions on one shared bus. Every synchronous input is captured on the rising clock edge: the address, the bus data, the three selects, the write controls and the burst controls. Reads leave through an output register and then a tri-state stage. Output enable and the snooze input bypass the clock and act on the drivers at once.

An access starts with one of two start strobes. The host strobe always starts a read. The controller strobe follows the write controls. After a start, the block generates the low two address bits of the following cycles itself, in linear or interleaved order. A step input chooses whether the address moves on or repeats. After a deselect, the drivers stay on for one cycle more than the read pipeline alone would keep them on. This lets several parts share the bus with no idle gap. The control is a two-state machine. In ST_IDLE no access runs. In ST_BURST an access runs on every edge.

The machine has five transitions. T_SELECT goes from ST_IDLE to ST_BURST on a start that finds all selects active. T_HOLD keeps ST_IDLE on any other edge. T_RELOAD stays in ST_BURST on a new selected start. T_CONTINUE stays in ST_BURST on an edge with no start. T_DROP goes from ST_BURST to ST_IDLE on a start that finds a select inactive.

Top module: `pbsram_core`

## Requirements
- R1: After reset the bus is not driven (dq_drive = 0) and the machine is in ST_IDLE.
- R2: A controller-started read registered at edge N, with no write control active, drives the stored word on dq with dq_drive = 1 after edge N+1 when oe_n is low.
- R3: A start is selected only when sel0_n = 0, sel1 = 1 and sel2_n = 0. A controller start with any select inactive performs no access and writes nothing. A host start with sel0_n = 1 is ignored altogether.
- R4: all_wr_n = 0 writes all four lanes, whatever lane_wr_en_n and lane_n are.
- R5: When all_wr_n = 1 and lane_wr_en_n = 0, lane i (dq bits 9i+8 down to 9i, parity included) is written only if lane_n[i] = 0. When all_wr_n = 1 and lane_wr_en_n = 1, the access is a read.
- R6: When interleave = 0 at the start, each continue cycle with step_n = 0 sets the low two address bits to the start value plus the step count, modulo 4. The upper bits stay fixed, so the fifth word wraps back to the start word.
- R7: When interleave = 1 at the start, the low two address bits of a burst are the start value XOR the step count.
- R8: A continue cycle with step_n = 1 accesses the same address again.
- R9: When a deselect is registered at edge D, one edge after a read, the drivers keep the last read word through edge D+1 and are off after edge D+2.
- R10: oe_n = 1 turns the drivers off at once, without waiting for a clock edge.
- R11: While snooze = 1 the drivers are off, every input is ignored, and all state and array contents are kept. Operation resumes at the first rising edge after snooze falls.
- R12: A read registered on the edge after a write to the same address returns the newly written word.
- R13: A host start with sel0_n = 0 and all selects active is a read, even if write controls are active in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset of pipeline and state |
| snooze | input | 1 | Asynchronous sleep; freezes the block and releases the bus |
| addr | input | ADDR_W | Word address loaded on a start |
| sel0_n | input | 1 | Active-low select; also qualifies the host strobe |
| sel1 | input | 1 | Active-high select |
| sel2_n | input | 1 | Active-low select |
| start_host_n | input | 1 | Host start strobe, always a read |
| start_ctl_n | input | 1 | Controller start strobe, read or write |
| step_n | input | 1 | Active-low burst advance in continue cycles |
| interleave | input | 1 | Burst order captured at start: 1 interleaved, 0 linear |
| all_wr_n | input | 1 | Active-low write of every lane |
| lane_wr_en_n | input | 1 | Active-low enable for per-lane writes |
| lane_n | input | LANES | Active-low per-lane write selects |
| oe_n | input | 1 | Asynchronous active-low output enable |
| dq | inout | LANES*LANE_W | Shared data bus |
| dq_drive | output | 1 | High while the block drives dq |

## Verification
Read data is due one edge after the edge that registers the access. The driver task enqueues each expected word tagged with that edge number, and the monitor compares it 1 ns after that edge, when all inputs are stable. For a deselect, the queue holds two entries: still driving at D+1 and released at D+2. Output enable and snooze act without a clock, so their checks are made a fraction of a nanosecond after the pin changes, between two edges. Array contents after writes, blocked writes and snooze are checked by reading the same address back through the bus.

// File: rtl/pbsram_pkg.sv
`timescale 1ns/100ps
package pbsram_pkg;
    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_BURST = 1'b1
    } bst_state_e;

    // Low address bits for burst position cnt from start value st.
    function automatic logic [1:0] burst_low(input logic [1:0] st,
                                             input logic [1:0] cnt,
                                             input logic ilv);
        return ilv ? (st ^ cnt) : (st + cnt);
    endfunction
endpackage

// File: rtl/pbsram_burst.sv
`timescale 1ns/100ps
module pbsram_burst #(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              step,
    input  logic              ilv_in,
    output logic [ADDR_W-1:0] acc_addr,
    output logic              ilv_mode
);
    import pbsram_pkg::*;

    logic [ADDR_W-1:0] base_q;
    logic [1:0]        cnt_q;
    logic [1:0]        cnt_nx;

    assign cnt_nx = step ? cnt_q + 2'd1 : cnt_q;

    always_comb begin
        if (load) acc_addr = load_addr;
        else      acc_addr = {base_q[ADDR_W-1:2], burst_low(base_q[1:0], cnt_nx, ilv_mode)};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q   <= '0;
            cnt_q    <= '0;
            ilv_mode <= 1'b0;
        end else if (ce) begin
            if (load) begin
                base_q   <= load_addr;
                cnt_q    <= '0;
                ilv_mode <= ilv_in;
            end else if (step) begin
                cnt_q <= cnt_nx;
            end
        end
    end
endmodule

// File: rtl/pbsram_array.sv
`timescale 1ns/100ps
module pbsram_array #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ce,
    input  logic                     wr_en,
    input  logic [LANES-1:0]         wr_mask,
    input  logic                     rd_en,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [LANES*LANE_W-1:0]  wdata,
    output logic [LANES*LANE_W-1:0]  rdata
);
    localparam int DW    = LANES * LANE_W;
    localparam int DEPTH = 1 << ADDR_W;

    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] bit_mask;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign bit_mask[g*LANE_W +: LANE_W] = {LANE_W{wr_mask[g]}};
    end

    always_ff @(posedge clk) begin
        if (ce && wr_en)
            mem[addr] <= (mem[addr] & ~bit_mask) | (wdata & bit_mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             rdata <= '0;
        else if (ce && rd_en)   rdata <= mem[addr];
    end
endmodule

// File: rtl/pbsram_drive.sv
`timescale 1ns/100ps
module pbsram_drive (
    input  logic clk,
    input  logic rst_n,
    input  logic ce,
    input  logic rd_fire,
    input  logic desel_fire,
    input  logic oe_n,
    input  logic snooze,
    output logic rd_vld,
    output logic dcd_hold,
    output logic drive
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_vld   <= 1'b0;
            dcd_hold <= 1'b0;
        end else if (ce) begin
            rd_vld   <= rd_fire;
            dcd_hold <= rd_vld && desel_fire;
        end
    end

    assign drive = (rd_vld || dcd_hold) && !oe_n && !snooze;
endmodule

// File: rtl/pbsram_core.sv
`timescale 1ns/100ps
module pbsram_core #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    localparam int DW    = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              snooze,
    input  logic [ADDR_W-1:0] addr,
    input  logic              sel0_n,
    input  logic              sel1,
    input  logic              sel2_n,
    input  logic              start_host_n,
    input  logic              start_ctl_n,
    input  logic              step_n,
    input  logic              interleave,
    input  logic              all_wr_n,
    input  logic              lane_wr_en_n,
    input  logic [LANES-1:0]  lane_n,
    input  logic              oe_n,
    inout  wire  [DW-1:0]     dq,
    output logic              dq_drive
);
    import pbsram_pkg::*;

    bst_state_e        state_q, state_nx;
    logic              ce;
    logic              host_go, ctl_go, go, chip_on;
    logic              load, access, desel, step;
    logic [LANES-1:0]  mask_in, wmask;
    logic [ADDR_W-1:0] burst_addr;
    logic              ilv_mode;

    logic              acc_valid_q, acc_wr_q, acc_desel_q;
    logic [LANES-1:0]  acc_mask_q;
    logic [ADDR_W-1:0] acc_addr_q;
    logic [DW-1:0]     acc_wdata_q;
    logic [DW-1:0]     rdata;
    logic              rd_vld, dcd_hold, drive;

    assign ce      = !snooze;
    assign host_go = !start_host_n && !sel0_n;
    assign ctl_go  = !start_ctl_n;
    assign go      = host_go || ctl_go;
    assign chip_on = !sel0_n && sel1 && !sel2_n;
    assign mask_in = !all_wr_n ? '1 : (!lane_wr_en_n ? ~lane_n : '0);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  state_q <= ST_IDLE;
        else if (ce) state_q <= state_nx;
    end

    // Next state and access decode
    always_comb begin
        state_nx = state_q;
        load     = 1'b0;
        access   = 1'b0;
        desel    = 1'b0;
        step     = 1'b0;
        wmask    = host_go ? '0 : mask_in;
        unique case (state_q)
            ST_IDLE: begin
                if (go && chip_on) begin
                    state_nx = ST_BURST;
                    load     = 1'b1;
                    access   = 1'b1;
                end else if (go) begin
                    desel = 1'b1;
                end
            end
            ST_BURST: begin
                if (go && chip_on) begin
                    load   = 1'b1;
                    access = 1'b1;
                end else if (go) begin
                    state_nx = ST_IDLE;
                    desel    = 1'b1;
                end else begin
                    access = 1'b1;
                    step   = !step_n;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    pbsram_burst #(.ADDR_W(ADDR_W)) u_burst (
        .clk       (clk),
        .rst_n     (rst_n),
        .ce        (ce),
        .load      (load),
        .load_addr (addr),
        .step      (step),
        .ilv_in    (interleave),
        .acc_addr  (burst_addr),
        .ilv_mode  (ilv_mode)
    );

    // Registered access stage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_valid_q <= 1'b0;
            acc_wr_q    <= 1'b0;
            acc_desel_q <= 1'b0;
            acc_mask_q  <= '0;
            acc_addr_q  <= '0;
            acc_wdata_q <= '0;
        end else if (ce) begin
            acc_valid_q <= access;
            acc_wr_q    <= access && (|wmask);
            acc_desel_q <= desel;
            acc_mask_q  <= wmask;
            acc_addr_q  <= burst_addr;
            acc_wdata_q <= dq;
        end
    end

    pbsram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .ce      (ce),
        .wr_en   (acc_valid_q && acc_wr_q),
        .wr_mask (acc_mask_q),
        .rd_en   (acc_valid_q && !acc_wr_q),
        .addr    (acc_addr_q),
        .wdata   (acc_wdata_q),
        .rdata   (rdata)
    );

    pbsram_drive u_drive (
        .clk        (clk),
        .rst_n      (rst_n),
        .ce         (ce),
        .rd_fire    (acc_valid_q && !acc_wr_q),
        .desel_fire (acc_desel_q),
        .oe_n       (oe_n),
        .snooze     (snooze),
        .rd_vld     (rd_vld),
        .dcd_hold   (dcd_hold),
        .drive      (drive)
    );

    assign dq       = drive ? rdata : 'z;
    assign dq_drive = drive;
endmodule

// File: rtl/pbsram_chk.sv
`timescale 1ns/100ps
module pbsram_chk #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     snooze,
    input logic                     oe_n,
    input logic                     dq_drive,
    input logic                     start_ctl_n,
    input logic                     start_host_n,
    input logic                     sel0_n,
    input logic                     sel1,
    input logic                     sel2_n,
    input logic                     all_wr_n,
    input logic                     lane_wr_en_n,
    input logic                     step_n,
    input logic                     in_burst,
    input logic                     ilv_mode,
    input logic [ADDR_W-1:0]        acc_addr,
    input logic                     dcd_hold,
    input logic [LANES*LANE_W-1:0]  rdata
);
    logic cont_cycle;
    assign cont_cycle = in_burst && start_ctl_n && (start_host_n || sel0_n) && !snooze;

    // R2: a selected controller read reaches the bus after the next edge
    a_r2_read_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_ctl_n && !sel0_n && sel1 && !sel2_n && all_wr_n && lane_wr_en_n && !snooze)
        ##1 !snooze |=> (oe_n || snooze || dq_drive));

    // R9: the extra deselect stage lasts exactly one cycle
    a_r9_dcd_single: assert property (@(posedge clk) disable iff (!rst_n)
        (dcd_hold && !snooze) |=> !dcd_hold);

    // R11: snooze freezes the pipeline
    a_r11_snooze_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        snooze |=> ($stable(rdata) && $stable(acc_addr) && $stable(in_burst)));

    // R6: linear step moves the low bits by one, upper bits fixed
    a_r6_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
        (cont_cycle && !step_n && !ilv_mode) |=>
        (acc_addr[1:0] == $past(acc_addr[1:0]) + 2'd1) &&
        (acc_addr[ADDR_W-1:2] == $past(acc_addr[ADDR_W-1:2])));

    // R8: no step repeats the address
    a_r8_hold_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (cont_cycle && step_n) |=> (acc_addr == $past(acc_addr)));
endmodule

bind pbsram_core pbsram_chk #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .snooze       (snooze),
    .oe_n         (oe_n),
    .dq_drive     (dq_drive),
    .start_ctl_n  (start_ctl_n),
    .start_host_n (start_host_n),
    .sel0_n       (sel0_n),
    .sel1         (sel1),
    .sel2_n       (sel2_n),
    .all_wr_n     (all_wr_n),
    .lane_wr_en_n (lane_wr_en_n),
    .step_n       (step_n),
    .in_burst     (state_q == pbsram_pkg::ST_BURST),
    .ilv_mode     (ilv_mode),
    .acc_addr     (acc_addr_q),
    .dcd_hold     (dcd_hold),
    .rdata        (rdata)
);

// File: tb/pbsram_core_tb.sv
`timescale 1ns/100ps
module pbsram_core_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        snooze = 1'b0;
    logic [5:0]  addr;
    logic        sel0_n, sel1, sel2_n;
    logic        start_host_n, start_ctl_n, step_n, interleave;
    logic        all_wr_n, lane_wr_en_n, oe_n;
    logic [3:0]  lane_n;
    logic [35:0] tb_dq;
    logic        tb_drv;
    logic        ilv_tb = 1'b0;
    wire  [35:0] dq;
    wire         dq_drive;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    int          due_q[$];
    logic [36:0] val_q[$];
    string       tag_q[$];

    assign dq = tb_drv ? tb_dq : 'z;

    always #2.5 clk = ~clk;

    pbsram_core u_dut (
        .clk(clk), .rst_n(rst_n), .snooze(snooze), .addr(addr),
        .sel0_n(sel0_n), .sel1(sel1), .sel2_n(sel2_n),
        .start_host_n(start_host_n), .start_ctl_n(start_ctl_n),
        .step_n(step_n), .interleave(interleave),
        .all_wr_n(all_wr_n), .lane_wr_en_n(lane_wr_en_n), .lane_n(lane_n),
        .oe_n(oe_n), .dq(dq), .dq_drive(dq_drive)
    );

    function automatic logic [35:0] wv(input logic [5:0] a);
        return {4'hA, 2'b00, a, 2'b01, a, 2'b10, a, 2'b11, a};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [36:0] act, input logic [36:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic expect_at(input int due, input logic drv, input logic [35:0] d, input string tag);
        due_q.push_back(due);
        val_q.push_back({drv, d});
        tag_q.push_back(tag);
    endtask

    // Monitor: compares queued expectations 1 ns after the due edge
    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            #1;
            while (due_q.size() > 0 && due_q[0] <= cyc) begin
                automatic int          d   = due_q.pop_front();
                automatic logic [36:0] e   = val_q.pop_front();
                automatic string       t   = tag_q.pop_front();
                automatic logic [36:0] act = {dq_drive, dq_drive ? dq : 36'h0};
                if (d != cyc) chk(1'b0, {t, " missed slot"}, 37'(cyc), 37'(d));
                else if (e[36]) chk(act == e, t, act, e);
                else chk(dq_drive == 1'b0, t, act, e);
            end
        end
    end

    task automatic quiet();
        start_host_n = 1'b1; start_ctl_n = 1'b1; step_n = 1'b1;
        all_wr_n = 1'b1; lane_wr_en_n = 1'b1; lane_n = 4'hF;
        sel0_n = 1'b0; sel1 = 1'b1; sel2_n = 1'b0;
        oe_n = 1'b0; tb_drv = 1'b0; tb_dq = '0; addr = '0;
        interleave = ilv_tb;
    endtask

    task automatic nop();
        @(negedge clk); quiet();
    endtask

    task automatic wr(input logic [5:0] a, input logic [35:0] d, input logic gw,
                      input logic bwe, input logic [3:0] ln);
        @(negedge clk); quiet();
        start_ctl_n = 1'b0; addr = a; all_wr_n = gw; lane_wr_en_n = bwe; lane_n = ln;
        oe_n = 1'b1; tb_drv = 1'b1; tb_dq = d;
    endtask

    task automatic wr_sel(input logic [5:0] a, input logic [35:0] d,
                          input logic s0, input logic s1, input logic s2);
        @(negedge clk); quiet();
        start_ctl_n = 1'b0; addr = a; all_wr_n = 1'b0;
        sel0_n = s0; sel1 = s1; sel2_n = s2;
        oe_n = 1'b1; tb_drv = 1'b1; tb_dq = d;
    endtask

    task automatic rd(input logic [5:0] a, input logic [35:0] d, input string tag);
        @(negedge clk); quiet();
        start_ctl_n = 1'b0; addr = a;
        expect_at(cyc + 2, 1'b1, d, tag);
    endtask

    task automatic rd_np(input logic [5:0] a);
        @(negedge clk); quiet();
        start_ctl_n = 1'b0; addr = a;
    endtask

    task automatic cont(input logic stp_n, input logic [35:0] d, input string tag);
        @(negedge clk); quiet();
        step_n = stp_n;
        expect_at(cyc + 2, 1'b1, d, tag);
    endtask

    task automatic desel_np();
        @(negedge clk); quiet();
        start_ctl_n = 1'b0; sel0_n = 1'b1;
    endtask

    // R9: deselect after a read, drivers held one more cycle
    task automatic desel_dcd(input logic [35:0] last);
        @(negedge clk); quiet();
        start_ctl_n = 1'b0; sel0_n = 1'b1;
        expect_at(cyc + 2, 1'b1, last, "R9 held after deselect");
        expect_at(cyc + 3, 1'b0, '0, "R9 released");
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        #1000000;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
        $finish;
    end

    initial begin
        logic [35:0] merged;
        quiet();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #0.5 chk(dq_drive == 1'b0, "R1 reset drive", 37'(dq_drive), 37'h0);
        nop(); nop();
        #0.5 chk(dq_drive == 1'b0, "R1 idle after reset", 37'(dq_drive), 37'h0);

        // preload with global writes (R4)
        for (int a = 'h14; a <= 'h1B; a++) wr(6'(a), wv(6'(a)), 1'b0, 1'b1, 4'hF);
        desel_np(); nop(); nop();

        // R4 and R9
        rd(6'h14, wv(6'h14), "R4 global write");
        desel_dcd(wv(6'h14));
        nop(); nop(); nop();

        // R5: lane writes, then a write-free access
        wr(6'h20, 36'hF_FFFF_FFFF, 1'b0, 1'b1, 4'h0);
        wr(6'h20, 36'h0, 1'b1, 1'b0, 4'b1010);
        merged = 36'hF_FFFF_FFFF;
        merged[8:0]   = 9'h0;
        merged[26:18] = 9'h0;
        desel_np(); nop();
        rd(6'h20, merged, "R5 lanes 0 and 2");
        desel_dcd(merged);
        nop(); nop(); nop();
        wr(6'h20, 36'h0, 1'b1, 1'b1, 4'h0);
        rd(6'h20, merged, "R5 no write when lane enable off");
        desel_dcd(merged);
        nop(); nop(); nop();

        // R12
        wr(6'h28, 36'h1_2345_6789, 1'b0, 1'b1, 4'hF);
        rd(6'h28, 36'h1_2345_6789, "R12 read after write");
        desel_dcd(36'h1_2345_6789);
        nop(); nop(); nop();

        // R6 linear with wrap, R8 hold
        rd(6'h16, wv(6'h16), "R6 start");
        cont(1'b0, wv(6'h17), "R6 step1");
        cont(1'b0, wv(6'h14), "R6 step2");
        cont(1'b0, wv(6'h15), "R6 step3");
        cont(1'b0, wv(6'h16), "R6 wrap");
        cont(1'b1, wv(6'h16), "R8 repeat");
        desel_dcd(wv(6'h16));
        nop(); nop(); nop();

        // R7 interleaved
        ilv_tb = 1'b1;
        rd(6'h19, wv(6'h19), "R7 start");
        cont(1'b0, wv(6'h18), "R7 step1");
        cont(1'b0, wv(6'h1B), "R7 step2");
        cont(1'b0, wv(6'h1A), "R7 step3");
        desel_dcd(wv(6'h1A));
        ilv_tb = 1'b0;
        nop(); nop(); nop();

        // R13: host start forces a read
        @(negedge clk); quiet();
        start_host_n = 1'b0; addr = 6'h15; all_wr_n = 1'b0; tb_drv = 1'b1; tb_dq = '0;
        expect_at(cyc + 2, 1'b1, wv(6'h15), "R13 host start reads");
        desel_dcd(wv(6'h15));
        nop(); nop(); nop();
        rd(6'h15, wv(6'h15), "R13 array unchanged");
        desel_dcd(wv(6'h15));
        nop(); nop(); nop();

        // R3: host start with sel0_n high is ignored
        @(negedge clk); quiet();
        start_host_n = 1'b0; sel0_n = 1'b1; addr = 6'h15;
        expect_at(cyc + 2, 1'b0, '0, "R3 host start unselected");
        nop(); nop();
        wr_sel(6'h17, 36'h0, 1'b0, 1'b0, 1'b0);
        wr_sel(6'h17, 36'h0, 1'b0, 1'b1, 1'b1);
        nop();
        rd(6'h17, wv(6'h17), "R3 blocked writes");
        desel_dcd(wv(6'h17));
        nop(); nop(); nop();

        // R2 and R10: output enable acts without a clock
        rd_np(6'h18);
        desel_np();
        @(posedge clk);
        #0.4 chk(dq_drive == 1'b1 && dq == wv(6'h18), "R2 data after next edge", {dq_drive, dq}, {1'b1, wv(6'h18)});
        oe_n = 1'b1;
        #0.2 chk(dq_drive == 1'b0, "R10 oe_n high", 37'(dq_drive), 37'h0);
        oe_n = 1'b0;
        #0.2 chk(dq_drive == 1'b1, "R10 oe_n low again", 37'(dq_drive), 37'h1);
        nop(); nop(); nop(); nop();

        // R11: snooze releases the bus at once
        rd_np(6'h19);
        desel_np();
        @(posedge clk);
        #0.4 snooze = 1'b1;
        #0.2 chk(dq_drive == 1'b0, "R11 bus off in snooze", 37'(dq_drive), 37'h0);
        @(negedge clk); snooze = 1'b0;
        nop(); nop(); nop(); nop();

        // R11: inputs ignored while snoozing, resume on first edge
        @(negedge clk); quiet();
        snooze = 1'b1; start_ctl_n = 1'b0; addr = 6'h14; all_wr_n = 1'b0;
        oe_n = 1'b1; tb_drv = 1'b1; tb_dq = 36'h0;
        @(negedge clk);
        @(negedge clk);
        snooze = 1'b0; quiet();
        start_ctl_n = 1'b0; addr = 6'h14;
        expect_at(cyc + 2, 1'b1, wv(6'h14), "R11 array kept, resumed");
        desel_dcd(wv(6'h14));
        repeat (5) nop();

        chk(due_q.size() == 0, "R2 all expectations consumed", 37'(due_q.size()), 37'h0);
        summary();
        $finish;
    end
endmodule